// File: doc/BRIEF.md
# Shared GPIO Bank Combiner for Eight Cores

This block lets several processor cores share one bank of I/O pins with no arbitration and no locking. Each core has two private registers, one for pin output levels and one for pin direction, and each register has its own write port. A write carries a data word and a bit mask, so a core can change single pins without disturbing the others.

On every pin, a core's output bit only counts while that core's direction bit for the pin is set. The pin is enabled when any core sets its direction bit. The level driven is the OR of the gated output bits of all cores, so a core that wants a pin high always wins over a core that wants it low. The enable and level are built combinationally from the registers, so a write shows up at the pad in the cycle after the clock edge that took it. Pad input values pass through a two-flop synchronizer onto one read bus that every core can sample at any time.

Top module: `gpio_share_top`

## Requirements
- R1: On a write to a core's output or direction register, each bit whose mask bit is 1 takes the data bit and each bit whose mask bit is 0 keeps its old value. The result is visible on that core's read-back port after the write edge. Core c uses bits [c*PIN_W +: PIN_W] of every flat bus.
- R2: pad_oe[p] is 1 exactly when at least one core has its direction bit p set.
- R3: A core whose direction bit p is clear has no effect on pin p. When no core has direction bit p set, pad_oe[p] is 0 and pad_do[p] is 0.
- R4: pad_do[p] is the OR, over all cores, of that core's output bit p ANDed with its direction bit p.
- R5: pad_oe and pad_do reflect a write immediately after the clock edge that takes it, with no extra wait cycle.
- R6: If a core sets output bit p to 1 and then, in a later write, sets direction bit p, pad_do[p] is already 1 in the first cycle that pad_oe[p] is 1. Symmetrically, a preset 0 gives pad_do[p] = 0 in that cycle.
- R7: pin_rd equals pad_in as sampled two clock edges earlier. It is one bus shared by all cores.
- R8: While rst_n is low, every register is zero. So pad_oe, pad_do, pin_rd and both read-back buses are all zero.
- R9: When two cores both enable pin p, and one drives 1 while the other drives 0, pad_do[p] is 1.
- R10: Writes from different cores in the same cycle each land in their own core's register, with no interference between cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_out_en | input | N_CORES | Per-core output-register write strobe |
| wr_out_data | input | N_CORES*PIN_W | Per-core output write data |
| wr_out_mask | input | N_CORES*PIN_W | Per-core output write bit mask |
| wr_dir_en | input | N_CORES | Per-core direction-register write strobe |
| wr_dir_data | input | N_CORES*PIN_W | Per-core direction write data |
| wr_dir_mask | input | N_CORES*PIN_W | Per-core direction write bit mask |
| pad_in | input | PIN_W | Raw pad input levels |
| pad_oe | output | PIN_W | Final output enable per pin |
| pad_do | output | PIN_W | Final drive level per pin |
| pin_rd | output | PIN_W | Synchronized pin levels, shared by all cores |
| core_out_rd | output | N_CORES*PIN_W | Read-back of every core's output register |
| core_dir_rd | output | N_CORES*PIN_W | Read-back of every core's direction register |

## Verification
The bench first aims at the release case: a pin where no core has its direction bit set must leave pad_do low. A design that skipped the per-core gating would let a stale output bit leak onto a released pin. It then checks two enabled cores pulling in opposite directions. A design that merged levels with AND, or by priority, would drive low where high must win. The preset-then-enable sequence exposes any gating that lags the direction register by a cycle, because that lag would briefly show the wrong level. Partial-mask writes, and same-cycle writes from several cores, catch a register that overwrites unmasked bits or lets one core's strobe reach another core.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  localparam int unsigned DEF_CORES = 8;
  localparam int unsigned DEF_PINS  = 32;
  localparam int unsigned SYNC_DEPTH = 2;

  // Apply a masked write to a register word.
  function automatic logic [DEF_PINS-1:0] masked_merge(
    input logic [DEF_PINS-1:0] old_v,
    input logic [DEF_PINS-1:0] new_v,
    input logic [DEF_PINS-1:0] msk
  );
    return (new_v & msk) | (old_v & ~msk);
  endfunction
endpackage

// File: rtl/core_pin_regs.sv
module core_pin_regs #(
  parameter int unsigned PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_we,
  input  logic [PIN_W-1:0] out_wdata,
  input  logic [PIN_W-1:0] out_wmask,
  input  logic             dir_we,
  input  logic [PIN_W-1:0] dir_wdata,
  input  logic [PIN_W-1:0] dir_wmask,
  output logic [PIN_W-1:0] out_q,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] gated
);
  logic [PIN_W-1:0] out_d, dir_d;

  always_comb begin
    out_d = (out_wdata & out_wmask) | (out_q & ~out_wmask);
    dir_d = (dir_wdata & dir_wmask) | (dir_q & ~dir_wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_we) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_we) begin
      dir_q <= dir_d;
    end
  end

  // a core without direction set contributes nothing to the pin
  assign gated = out_q & dir_q;
endmodule

// File: rtl/pin_merge.sv
module pin_merge #(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned PIN_W   = 32
) (
  input  logic [N_CORES*PIN_W-1:0] dir_all,
  input  logic [N_CORES*PIN_W-1:0] gated_all,
  output logic [PIN_W-1:0]         oe,
  output logic [PIN_W-1:0]         lvl
);
  always_comb begin
    oe  = '0;
    lvl = '0;
    for (int c = 0; c < int'(N_CORES); c++) begin
      oe  = oe  | dir_all[c*PIN_W +: PIN_W];
      lvl = lvl | gated_all[c*PIN_W +: PIN_W];
    end
  end
endmodule

// File: rtl/in_sync.sv
module in_sync #(
  parameter int unsigned PIN_W = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] d,
  output logic [PIN_W-1:0] q
);
  logic [PIN_W-1:0] stage_q [DEPTH];
  logic [PIN_W-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < int'(DEPTH); i++) stage_d[i] = stage_q[i-1];
  end

  generate
    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_d[i];
      end
    end
  endgenerate

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/gpio_share_top.sv
module gpio_share_top
  import gpio_share_pkg::*;
#(
  parameter int unsigned N_CORES = DEF_CORES,
  parameter int unsigned PIN_W   = DEF_PINS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CORES-1:0]       wr_out_en,
  input  logic [N_CORES*PIN_W-1:0] wr_out_data,
  input  logic [N_CORES*PIN_W-1:0] wr_out_mask,
  input  logic [N_CORES-1:0]       wr_dir_en,
  input  logic [N_CORES*PIN_W-1:0] wr_dir_data,
  input  logic [N_CORES*PIN_W-1:0] wr_dir_mask,
  input  logic [PIN_W-1:0]         pad_in,
  output logic [PIN_W-1:0]         pad_oe,
  output logic [PIN_W-1:0]         pad_do,
  output logic [PIN_W-1:0]         pin_rd,
  output logic [N_CORES*PIN_W-1:0] core_out_rd,
  output logic [N_CORES*PIN_W-1:0] core_dir_rd
);
  localparam int unsigned BUS_W = N_CORES * PIN_W;

  logic [BUS_W-1:0] gated_all;

  generate
    for (genvar c = 0; c < int'(N_CORES); c++) begin : g_core
      core_pin_regs #(.PIN_W(PIN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_we    (wr_out_en[c]),
        .out_wdata (wr_out_data[c*PIN_W +: PIN_W]),
        .out_wmask (wr_out_mask[c*PIN_W +: PIN_W]),
        .dir_we    (wr_dir_en[c]),
        .dir_wdata (wr_dir_data[c*PIN_W +: PIN_W]),
        .dir_wmask (wr_dir_mask[c*PIN_W +: PIN_W]),
        .out_q     (core_out_rd[c*PIN_W +: PIN_W]),
        .dir_q     (core_dir_rd[c*PIN_W +: PIN_W]),
        .gated     (gated_all[c*PIN_W +: PIN_W])
      );
    end
  endgenerate

  pin_merge #(.N_CORES(N_CORES), .PIN_W(PIN_W)) u_merge (
    .dir_all   (core_dir_rd),
    .gated_all (gated_all),
    .oe        (pad_oe),
    .lvl       (pad_do)
  );

  in_sync #(.PIN_W(PIN_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_rd)
  );
endmodule

// File: rtl/gpio_share_chk.sv
module gpio_share_chk #(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned PIN_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_CORES-1:0]       wr_dir_en,
  input logic [N_CORES*PIN_W-1:0] wr_dir_data,
  input logic [N_CORES*PIN_W-1:0] wr_dir_mask,
  input logic [PIN_W-1:0]         pad_in,
  input logic [PIN_W-1:0]         pad_oe,
  input logic [PIN_W-1:0]         pad_do,
  input logic [PIN_W-1:0]         pin_rd,
  input logic [N_CORES*PIN_W-1:0] core_out_rd
);
  logic [PIN_W-1:0] all_hi, any_hi;
  logic [1:0]       live_cnt;

  always_comb begin
    all_hi = '1;
    any_hi = '0;
    for (int c = 0; c < int'(N_CORES); c++) begin
      all_hi = all_hi & core_out_rd[c*PIN_W +: PIN_W];
      any_hi = any_hi | core_out_rd[c*PIN_W +: PIN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             live_cnt <= '0;
    else if (live_cnt != 2) live_cnt <= live_cnt + 2'd1;
  end

  // R3
  released_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & ~pad_oe) == '0);

  // R6
  preset_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_hi & pad_oe & ~pad_do) == '0);

  // R6
  preset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~any_hi & pad_do) == '0);

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 2) |-> (pin_rd == $past(pad_in, 2)));

  generate
    for (genvar c = 0; c < int'(N_CORES); c++) begin : g_dirw
      // R1
      dir_mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir_en[c] |=> (pad_oe | ~(($past(wr_dir_data[c*PIN_W +: PIN_W])
                            & $past(wr_dir_mask[c*PIN_W +: PIN_W])))) == '1);
    end
  endgenerate
endmodule

bind gpio_share_top gpio_share_chk #(.N_CORES(N_CORES), .PIN_W(PIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_dir_en   (wr_dir_en),
  .wr_dir_data (wr_dir_data),
  .wr_dir_mask (wr_dir_mask),
  .pad_in      (pad_in),
  .pad_oe      (pad_oe),
  .pad_do      (pad_do),
  .pin_rd      (pin_rd),
  .core_out_rd (core_out_rd)
);

// File: tb/tb_gpio_share_top.sv
`timescale 1ns/1ps
module tb_gpio_share_top;
  localparam int NC = 8;
  localparam int PW = 32;
  localparam int BW = NC * PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] wr_out_en = '0, wr_dir_en = '0;
  logic [BW-1:0] wr_out_data = '0, wr_out_mask = '0;
  logic [BW-1:0] wr_dir_data = '0, wr_dir_mask = '0;
  logic [PW-1:0] pad_in = '0;
  logic [PW-1:0] pad_oe, pad_do, pin_rd;
  logic [BW-1:0] core_out_rd, core_dir_rd;

  always #2 clk = ~clk;

  gpio_share_top #(.N_CORES(NC), .PIN_W(PW)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_out_en(wr_out_en), .wr_out_data(wr_out_data), .wr_out_mask(wr_out_mask),
    .wr_dir_en(wr_dir_en), .wr_dir_data(wr_dir_data), .wr_dir_mask(wr_dir_mask),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pin_rd(pin_rd),
    .core_out_rd(core_out_rd), .core_dir_rd(core_dir_rd)
  );

  // behavioural reference
  bit [PW-1:0] m_out [NC];
  bit [PW-1:0] m_dir [NC];
  bit [PW-1:0] in_q [$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  function automatic bit [PW-1:0] exp_oe();
    bit [PW-1:0] r = '0;
    for (int c = 0; c < NC; c++) r |= m_dir[c];
    return r;
  endfunction

  function automatic bit [PW-1:0] exp_do();
    bit [PW-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < PW; p++)
        if (m_dir[c][p] && m_out[c][p]) r[p] = 1'b1;
    return r;
  endfunction

  function automatic bit [BW-1:0] flat(input bit sel_dir);
    bit [BW-1:0] r;
    for (int c = 0; c < NC; c++) r[c*PW +: PW] = sel_dir ? m_dir[c] : m_out[c];
    return r;
  endfunction

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int c = 0; c < NC; c++) begin m_out[c] = '0; m_dir[c] = '0; end
    in_q.delete();
    in_q.push_back('0); in_q.push_back('0);
  endtask

  task automatic compare_all();
    check("R2 pad_oe", BW'(pad_oe), BW'(exp_oe()));
    check("R4 pad_do", BW'(pad_do), BW'(exp_do()));
    check("R7 pin_rd", BW'(pin_rd), BW'(in_q[0]));
    check("R1 core_out_rd", core_out_rd, flat(1'b0));
    check("R1 core_dir_rd", core_dir_rd, flat(1'b1));
  endtask

  // one clock: model follows the inputs that were stable at the edge
  task automatic tick();
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      for (int p = 0; p < PW; p++) begin
        if (wr_out_en[c] && wr_out_mask[c*PW+p]) m_out[c][p] = wr_out_data[c*PW+p];
        if (wr_dir_en[c] && wr_dir_mask[c*PW+p]) m_dir[c][p] = wr_dir_data[c*PW+p];
      end
    end
    void'(in_q.pop_front());
    in_q.push_back(pad_in);
    @(negedge clk);
    compare_all();
    wr_out_en = '0;
    wr_dir_en = '0;
  endtask

  task automatic wr_out(input int c, input logic [PW-1:0] d, input logic [PW-1:0] m);
    wr_out_en[c] = 1'b1;
    wr_out_data[c*PW +: PW] = d;
    wr_out_mask[c*PW +: PW] = m;
  endtask

  task automatic wr_dir(input int c, input logic [PW-1:0] d, input logic [PW-1:0] m);
    wr_dir_en[c] = 1'b1;
    wr_dir_data[c*PW +: PW] = d;
    wr_dir_mask[c*PW +: PW] = m;
  endtask

  initial begin
    reset_model();
    pad_in = 32'hDEAD_BEEF;
    wr_out_en = '1; wr_out_mask = '1; wr_out_data = '1;
    repeat (3) @(negedge clk);
    // R8: reset holds everything at zero
    check("R8 reset pad_oe", BW'(pad_oe), '0);
    check("R8 reset pad_do", BW'(pad_do), '0);
    check("R8 reset pin_rd", BW'(pin_rd), '0);
    check("R8 reset core_out_rd", core_out_rd, '0);
    wr_out_en = '0; wr_out_data = '0; wr_out_mask = '0;
    pad_in = '0;
    rst_n = 1'b1;
    tick();

    // R3: output bits set but no direction -> pin released and low
    wr_out(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    tick();
    check("R3 released oe", BW'(pad_oe), '0);
    check("R3 released do", BW'(pad_do), '0);

    // R6/R5: core2 already preset high on pin 4; enabling gives high at once
    wr_dir(2, 32'h0000_0010, 32'h0000_0010);
    tick();
    check("R5 oe same cycle", BW'(pad_oe[4]), BW'(1));
    check("R6 preset high", BW'(pad_do[4]), BW'(1));

    // R6: preset low on pin 9 via core 5 then enable
    wr_out(5, 32'h0, 32'h0000_0200);
    tick();
    wr_dir(5, 32'h0000_0200, 32'h0000_0200);
    tick();
    check("R6 preset low oe", BW'(pad_oe[9]), BW'(1));
    check("R6 preset low do", BW'(pad_do[9]), BW'(0));

    // R9: cores 1 and 3 fight on pin 5, high wins
    wr_out(1, 32'h0000_0020, 32'h0000_0020);
    wr_out(3, 32'h0000_0000, 32'h0000_0020);
    wr_dir(1, 32'h0000_0020, 32'h0000_0020);
    wr_dir(3, 32'h0000_0020, 32'h0000_0020);
    tick();
    check("R9 opposite resolve", BW'(pad_do[5]), BW'(1));

    // R1: partial-mask write keeps other bits of core 2
    wr_out(2, 32'h0000_0000, 32'h0000_FF00);
    tick();
    check("R1 masked keep", BW'(core_out_rd[2*PW +: PW]), BW'(32'hFFFF_00FF));

    // R10: simultaneous writes from cores 0 and 7 land separately
    wr_dir(0, 32'hA5A5_0000, 32'hFFFF_0000);
    wr_dir(7, 32'h0000_5A5A, 32'h0000_FFFF);
    tick();
    check("R10 core0 dir", BW'(core_dir_rd[0 +: PW]), BW'(32'hA5A5_0000));
    check("R10 core7 dir", BW'(core_dir_rd[7*PW +: PW]), BW'(32'h0000_5A5A));

    // R7: pad value appears after two edges
    pad_in = 32'h1357_9BDF;
    tick();
    check("R7 one edge not yet", BW'(pin_rd), '0);
    tick();
    check("R7 two edges", BW'(pin_rd), BW'(32'h1357_9BDF));

    // random traffic against the reference on every clock
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(0, 3) == 0) wr_out(c, $urandom, $urandom);
        if ($urandom_range(0, 5) == 0) wr_dir(c, $urandom, $urandom & $urandom);
      end
      pad_in = $urandom;
      tick();
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule